// File: doc/BRIEF.md
# Timer Gate Conditioning Unit

This unit produces the count-enable for a timer from one of four gate sources, chosen by a 2-bit select: an external gate pin, the overflow of another timer, or one of two comparator outputs that are already synchronised. The chosen source can be inverted. A divide-by-two stage can then be switched in. In that mode the enable is high for a whole period of the source instead of one level phase.

A single-pulse acquisition mode lets software arm one measurement by setting a go bit. The next complete active pulse then opens the enable exactly once. The go bit clears by itself when that pulse ends, and a gate-event flag is raised at the same time. The conditioned gate level can always be read as a status output. All gate inputs are sampled on the system clock. Each output reflects the inputs sampled at the clock edge that produced it, with no extra delay. The counter itself is outside this unit.

Top module: `tmr_gate_cond`

## Requirements
- R1: Select `src_sel_i` picks the gate source. 0 selects `pin_i`, 1 selects `ovf_i`, 2 selects `cmp1_i` and 3 selects `cmp2_i`. The other sources have no effect.
- R2: When `invert_i` is 1, the selected source is inverted before any further stage. An "active edge" is a 0-to-1 change of the signal after this inversion.
- R3: With toggle off, `gate_val_o` equals the inverted-as-configured source value sampled at the previous clock edge. With single-pulse off and run on, `gate_en_o` equals `gate_val_o`.
- R4: With toggle on, the conditioned level flips on every active edge. While `run_i` is 0 it is held at 0.
- R5: When `one_shot_i` is 0, a pulse on `go_set_i` is ignored: `go_o` stays 0.
- R6: In single-pulse mode with `go_o` set, the enable rises only on an active edge of the conditioned level that is sampled after the cycle in which the unit was armed. A level that is already high does not open it. The enable stays high until the conditioned level next falls.
- R7: When an armed pulse ends, `go_o` clears, `evt_o` sets, and later pulses leave the enable low until the unit is armed again.
- R8: `evt_clr_i` clears `evt_o`. If completion and clear happen in the same cycle, the set takes priority.
- R9: With toggle and single-pulse both on, the single window spans one full toggled period: from one active source edge to the next.
- R10: While `run_i` is 0, `gate_en_o` is 0. `gate_val_o` still reports the level.
- R11: After reset, `gate_en_o`, `gate_val_o`, `go_o` and `evt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Timer run bit |
| src_sel_i | input | 2 | Gate source select |
| pin_i | input | 1 | External gate pin |
| ovf_i | input | 1 | Overflow of another timer |
| cmp1_i | input | 1 | Comparator 1 output, synchronised |
| cmp2_i | input | 1 | Comparator 2 output, synchronised |
| invert_i | input | 1 | Source polarity invert |
| toggle_i | input | 1 | Divide-by-two toggle mode |
| one_shot_i | input | 1 | Single-pulse acquisition mode |
| go_set_i | input | 1 | One-cycle request to arm an acquisition |
| evt_clr_i | input | 1 | One-cycle clear of the gate-event flag |
| gate_en_o | output | 1 | Count enable for the timer |
| gate_val_o | output | 1 | Conditioned gate level |
| go_o | output | 1 | Acquisition armed or in progress |
| evt_o | output | 1 | Gate-event interrupt flag |

## Verification
If the sample register holds a wrong value, `gate_val_o` shows it in the very next cycle. Every source-and-polarity combination is swept, with the unselected sources driven to the opposite value, so a wrong mux leg or a missed inversion appears at once. A toggle flip-flop left in the wrong phase makes the output sequence over a run of pulses come out inverted within one source period. A wrong one-shot state shows up as the enable opening on a level that was already high, staying open after completion, or `go_o`/`evt_o` failing to change on the cycle the armed pulse ends.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
    localparam int SEL_W = 2;
    localparam int N_SRC = 1 << SEL_W;

    typedef struct packed {
        logic samp;
    } samp_t;

    typedef struct packed {
        logic tgl;
        logic lvl;
    } cond_t;

    typedef struct packed {
        logic go;
        logic open;
        logic evt;
    } shot_t;
endpackage

// File: rtl/tgc_sample.sv
module tgc_sample
    import tgc_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int NS = N_SRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] src_vec_i,
    input  logic [SW-1:0] sel_i,
    input  logic          invert_i,
    output logic          samp_d_o,
    output logic          samp_q_o
);
    samp_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.samp = src_vec_i[sel_i] ^ invert_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign samp_d_o = st_d.samp;
    assign samp_q_o = st_q.samp;
endmodule

// File: rtl/tgc_toggle.sv
module tgc_toggle
    import tgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic toggle_i,
    input  logic samp_d_i,
    input  logic samp_q_i,
    output logic lvl_d_o,
    output logic lvl_q_o
);
    cond_t c_d, c_q;
    logic  rise;

    always_comb begin
        rise    = samp_d_i & ~samp_q_i;
        c_d     = c_q;
        c_d.tgl = run_i ? (c_q.tgl ^ rise) : 1'b0;
        c_d.lvl = toggle_i ? c_d.tgl : samp_d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign lvl_d_o = c_d.lvl;
    assign lvl_q_o = c_q.lvl;

    // R4: toggle stage held clear while the timer is stopped
    p_tgl_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !c_q.tgl);
endmodule

// File: rtl/tgc_shot.sv
module tgc_shot
    import tgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shot_i,
    input  logic go_set_i,
    input  logic evt_clr_i,
    input  logic lvl_d_i,
    input  logic lvl_q_i,
    output logic open_o,
    output logic go_o,
    output logic evt_o
);
    shot_t s_d, s_q;
    logic  rise, fall, done;

    always_comb begin
        rise = lvl_d_i & ~lvl_q_i;
        fall = ~lvl_d_i & lvl_q_i;
        done = shot_i & s_q.open & fall;
        s_d  = s_q;
        if (!shot_i) begin
            s_d.go   = 1'b0;
            s_d.open = 1'b0;
        end else begin
            if (s_q.open) begin
                if (fall) begin
                    s_d.open = 1'b0;
                    s_d.go   = 1'b0;
                end
            end else if (s_q.go && rise) begin
                s_d.open = 1'b1;
            end
            if (go_set_i) s_d.go = 1'b1;
        end
        if (done)           s_d.evt = 1'b1;
        else if (evt_clr_i) s_d.evt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign open_o = s_q.open;
    assign go_o   = s_q.go;
    assign evt_o  = s_q.evt;

    // R6: an open window implies the conditioned level is high
    p_open_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.open |-> lvl_q_i);
    // R7: completion clears go unless re-armed in the same cycle
    p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shot_i && s_q.open && !lvl_d_i && !go_set_i) |=> !s_q.go);
    // R7: completion raises the event flag
    p_done_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shot_i && s_q.open && !lvl_d_i) |=> s_q.evt);
    // R5: go cannot be held outside single-pulse mode
    p_off_no_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !shot_i |=> !s_q.go);
endmodule

// File: rtl/tmr_gate_cond.sv
module tmr_gate_cond
    import tgc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] src_sel_i,
    input  logic             pin_i,
    input  logic             ovf_i,
    input  logic             cmp1_i,
    input  logic             cmp2_i,
    input  logic             invert_i,
    input  logic             toggle_i,
    input  logic             one_shot_i,
    input  logic             go_set_i,
    input  logic             evt_clr_i,
    output logic             gate_en_o,
    output logic             gate_val_o,
    output logic             go_o,
    output logic             evt_o
);
    logic [N_SRC-1:0] src_vec;
    logic samp_d, samp_q, lvl_d, lvl_q, open;

    assign src_vec = {cmp2_i, cmp1_i, ovf_i, pin_i};

    tgc_sample #(.SW(SEL_W), .NS(N_SRC)) u_sample (
        .clk(clk), .rst_n(rst_n), .src_vec_i(src_vec), .sel_i(src_sel_i),
        .invert_i(invert_i), .samp_d_o(samp_d), .samp_q_o(samp_q));

    tgc_toggle u_toggle (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .toggle_i(toggle_i),
        .samp_d_i(samp_d), .samp_q_i(samp_q), .lvl_d_o(lvl_d), .lvl_q_o(lvl_q));

    tgc_shot u_shot (
        .clk(clk), .rst_n(rst_n), .shot_i(one_shot_i), .go_set_i(go_set_i),
        .evt_clr_i(evt_clr_i), .lvl_d_i(lvl_d), .lvl_q_i(lvl_q),
        .open_o(open), .go_o(go_o), .evt_o(evt_o));

    assign gate_val_o = lvl_q;
    assign gate_en_o  = run_i & (one_shot_i ? open : lvl_q);

    // R6: in single-pulse mode the enable is only high while armed
    p_shot_needs_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (one_shot_i && gate_en_o) |-> go_o);
endmodule

// File: tb/test_tmr_gate_cond.sv
module test_tmr_gate_cond;
    logic clk = 0, rst_n = 0;
    logic run_i = 0, pin_i = 0, ovf_i = 0, cmp1_i = 0, cmp2_i = 0;
    logic [1:0] src_sel_i = 0;
    logic invert_i = 0, toggle_i = 0, one_shot_i = 0, go_set_i = 0, evt_clr_i = 0;
    logic gate_en_o, gate_val_o, go_o, evt_o;
    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tmr_gate_cond i_tmr_gate_cond (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive_src(int sel, logic v);
        pin_i  = (sel == 0) ? v : ~v;
        ovf_i  = (sel == 1) ? v : ~v;
        cmp1_i = (sel == 2) ? v : ~v;
        cmp2_i = (sel == 3) ? v : ~v;
    endtask

    task automatic go_pulse();
        go_set_i = 1; tick(); go_set_i = 0;
    endtask

    task automatic clr_pulse();
        evt_clr_i = 1; tick(); evt_clr_i = 0;
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        #1;
        // R11 reset state
        chk("R11 en", gate_en_o, 0);
        chk("R11 val", gate_val_o, 0);
        chk("R11 go", go_o, 0);
        chk("R11 evt", evt_o, 0);

        // R1 R2 R3 sweep of select, polarity and value
        run_i = 1;
        for (int s = 0; s < 4; s++)
            for (int inv = 0; inv < 2; inv++)
                for (int v = 0; v < 2; v++) begin
                    src_sel_i = s[1:0];
                    invert_i  = inv[0];
                    drive_src(s, v[0]);
                    tick();
                    chk("R1 R2 R3 val", gate_val_o, v[0] ^ inv[0]);
                    chk("R3 en", gate_en_o, v[0] ^ inv[0]);
                end

        // R10 run low masks the enable, level still reported
        src_sel_i = 0; invert_i = 0; drive_src(0, 1); tick();
        run_i = 0; tick();
        chk("R10 en", gate_en_o, 0);
        chk("R10 val", gate_val_o, 1);

        // R4 toggle mode, non-inverted
        toggle_i = 1; pin_i = 0; tick();
        chk("R4 held", gate_val_o, 0);
        run_i = 1;
        pin_i = 1; tick(); chk("R4 t1", gate_val_o, 1); chk("R4 en", gate_en_o, 1);
        pin_i = 0; tick(); chk("R4 t2", gate_val_o, 1);
        pin_i = 1; tick(); chk("R4 t3", gate_val_o, 0);
        pin_i = 0; tick(); chk("R4 t4", gate_val_o, 0);
        pin_i = 1; tick(); chk("R4 t5", gate_val_o, 1);
        run_i = 0; tick(); chk("R4 run clear", gate_val_o, 0);
        chk("R10 toggle en", gate_en_o, 0);
        // R4 with R2 inversion: active edge is pin falling
        run_i = 1; invert_i = 1; tick(); chk("R4 inv t0", gate_val_o, 0);
        pin_i = 0; tick(); chk("R4 inv t1", gate_val_o, 1);
        pin_i = 1; tick(); chk("R4 inv t2", gate_val_o, 1);
        pin_i = 0; tick(); chk("R4 inv t3", gate_val_o, 0);

        // R5 go ignored when single-pulse off
        toggle_i = 0; invert_i = 0; pin_i = 0; tick();
        go_pulse(); chk("R5 go", go_o, 0);

        // R6 R7 single-pulse with level already high at arm time
        one_shot_i = 1; pin_i = 1; tick();
        chk("R6 idle en", gate_en_o, 0);
        chk("R3 val in shot", gate_val_o, 1);
        go_pulse(); chk("R6 armed go", go_o, 1); chk("R6 armed en", gate_en_o, 0);
        tick(); chk("R6 high no open", gate_en_o, 0);
        pin_i = 0; tick(); chk("R6 low", gate_en_o, 0);
        pin_i = 1; tick(); chk("R6 open", gate_en_o, 1);
        tick(); chk("R6 stays", gate_en_o, 1);
        chk("R7 go busy", go_o, 1); chk("R7 evt pre", evt_o, 0);
        pin_i = 0; tick();
        chk("R6 close", gate_en_o, 0); chk("R7 go clr", go_o, 0); chk("R7 evt", evt_o, 1);
        pin_i = 1; tick(); chk("R7 ignored", gate_en_o, 0);
        pin_i = 0; tick();
        clr_pulse(); chk("R8 clr", evt_o, 0);

        // R6 edge in the arming cycle does not open
        pin_i = 1; go_set_i = 1; tick(); go_set_i = 0;
        chk("R6 arm-cycle edge", gate_en_o, 0); chk("R6 go", go_o, 1);
        pin_i = 0; tick(); chk("R6 low2", gate_en_o, 0);
        pin_i = 1; tick(); chk("R6 open2", gate_en_o, 1);
        // R8 set wins over clear
        pin_i = 0; evt_clr_i = 1; tick(); evt_clr_i = 0;
        chk("R8 set wins", evt_o, 1); chk("R7 go clr2", go_o, 0);
        clr_pulse(); chk("R8 clr2", evt_o, 0);

        // R9 toggle plus single-pulse: window of one full period
        toggle_i = 1; run_i = 0; tick(); run_i = 1; tick();
        go_pulse(); chk("R9 armed", go_o, 1);
        pin_i = 1; tick(); chk("R9 open", gate_en_o, 1);
        pin_i = 0; tick(); chk("R9 through low", gate_en_o, 1);
        pin_i = 1; tick();
        chk("R9 close", gate_en_o, 0); chk("R9 evt", evt_o, 1); chk("R9 go", go_o, 0);
        pin_i = 0; tick(); pin_i = 1; tick();
        chk("R9 val", gate_val_o, 1); chk("R9 no reopen", gate_en_o, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule